// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block decides when an I2C master may place a start or repeated-start condition on the bus, and then produces it. Software raises a one-bit start request. Depending on whether the bus is idle, whether another master owns it, and whether this device already owns it and is parked in its wait state, the block does one of four things. It launches the start at once. It keeps the request pending until the bus frees up. It drops the request and raises a rejection flag. Or it releases the wait and produces a repeated start.

The block pulls SDA and SCL low through open-drain enables and senses both lines to track bus ownership. The byte engine, the stop generator and the software register path are separate. They reach this block only as single-bit strobes and levels: the stop request, the release command, the wait, receive-mode and ACK-enable levels, and arbitration loss. When SCL is first pulled low after the start condition, the block emits a one-cycle done pulse so the byte engine can begin shifting the address.

One programmable cycle count, `hold_cnt_i`, sets the length of every timed phase. A value of zero is treated as one. The same count sets how long the lines must stay quiet before the bus is considered free.

Top module: `i2c_start_ctrl`

## Requirements
- R1: With the bus free and this device not owning it, an accepted request pulls SDA low with SCL released at the next clock edge, and `trig_o` reads 1. H edges later (H = effective hold count), SCL is also pulled low, `start_done_o` is 1 and `trig_o` returns to 0. The device then owns the bus and keeps both lines low.
- R2: The effective hold count H equals `hold_cnt_i`, except that 0 is treated as 1.
- R3: While the device owns the bus, an accepted request runs a restart. For H edges SDA is released with SCL held low. For H edges both lines are released. For H edges SDA is low with SCL released. Then SCL is pulled low together with a `start_done_o` pulse, so the done pulse comes 3H edges after acceptance.
- R4: With `rsv_dis_i` = 0, a request made while the bus is busy or not yet free sets `trig_o` = 1 without driving either line. The start is launched on the edge after the bus becomes free.
- R5: With `rsv_dis_i` = 1, a request made while another master holds the bus drives no line and leaves `trig_o` at 0. It sets `rej_o` to 1 on the next edge.
- R6: `rej_o` stays 1 until `rej_clr_i` is pulsed or `en_i` drops. If a new rejection and a clear strobe arrive in the same cycle, the rejection wins.
- R7: `trig_o` clears on the edge where `arb_lost_i`, `release_i` or a low `en_i` is sampled. Arbitration loss and release also abort a running sequence and release both lines.
- R8: A request sampled together with `stop_req_i` = 1 is ignored: `trig_o` stays 0 and no line is driven.
- R9: While `trig_o` is 1, further requests have no effect. In particular, they cannot cause a rejection.
- R10: While the device owns the bus in transmit mode (`mst_rx_i` = 0), a request is accepted only when `mst_wait_i` = 1, which marks the wait after the ninth clock. Otherwise it is ignored and `trig_o` stays 0.
- R11: While the device owns the bus in receive mode (`mst_rx_i` = 1), a request is accepted only when `mst_wait_i` = 1 and `ack_en_i` = 0. Otherwise it is ignored.
- R12: The bus counts as busy from a sensed start (SDA falling while SCL is high) until a sensed stop (SDA rising while SCL is high). It counts as free once it has been not busy for H consecutive edges with `en_i` high. `en_i` low forces it not busy.
- R13: `start_done_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low clears all state |
| hold_cnt_i | input | CNT_W | Phase length and bus-free count in cycles (0 means 1) |
| trig_wr_i | input | 1 | Software writes 1 to the start request |
| stop_req_i | input | 1 | Stop request written in this cycle |
| release_i | input | 1 | Communication-release command |
| rej_clr_i | input | 1 | Clears the rejection flag |
| rsv_dis_i | input | 1 | 1 disables reservation of a start on a busy bus |
| arb_lost_i | input | 1 | Arbitration loss reported by the byte engine |
| mst_wait_i | input | 1 | Owner is in the wait period after the ninth clock |
| mst_rx_i | input | 1 | Owner is receiving (1) or transmitting (0) |
| ack_en_i | input | 1 | ACK generation enabled |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| trig_o | output | 1 | Readable start request bit |
| rej_o | output | 1 | Start-rejected flag |
| start_done_o | output | 1 | One-cycle pulse when SCL is pulled low after a start |

## Verification
Two pairs of functions can fall in the same cycle. A request can arrive together with a stop request, which must leave the request at 0. A fresh rejection can coincide with the rejection-clear strobe, in which case the flag must stay set. The bench drives each pair on one clock edge against a busy or free bus produced by its own open-drain line model, and judges the result at the ports on the following cycle. Randomized restart attempts also mix the wait, receive-mode and ACK-enable levels, so that an accepted or refused restart lands on the same edge where the owning state is tested.

// File: rtl/i2c_sc_pkg.sv
package i2c_sc_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_HOLD   = 3'd1,
        SQ_MWAIT  = 3'd2,
        SQ_RS_SDA = 3'd3,
        SQ_RS_SCL = 3'd4
    } seq_state_e;

endpackage

// File: rtl/i2c_sc_busmon.sv
module i2c_sc_busmon #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [CNT_W-1:0] hmin_i,
    output logic             busy_o,
    output logic             free_o,
    output logic             stop_det_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             prev_scl;
        logic             prev_sda;
        logic             busy;
        logic [CNT_W-1:0] quiet;
    } mon_t;

    mon_t q, d;
    logic start_det;
    logic stop_det;

    always_comb begin
        start_det = q.prev_scl && scl_i && q.prev_sda && !sda_i;
        stop_det  = q.prev_scl && scl_i && !q.prev_sda && sda_i;
        d          = q;
        d.prev_scl = scl_i;
        d.prev_sda = sda_i;
        if (!en_i) begin
            d.busy  = 1'b0;
            d.quiet = '0;
        end else if (start_det) begin
            d.busy  = 1'b1;
            d.quiet = '0;
        end else if (stop_det) begin
            d.busy  = 1'b0;
            d.quiet = '0;
        end else if (q.busy) begin
            d.quiet = '0;
        end else if (q.quiet < hmin_i) begin
            d.quiet = q.quiet + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{prev_scl: 1'b1, prev_sda: 1'b1, busy: 1'b0, quiet: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign free_o     = !q.busy && (q.quiet >= hmin_i);
    assign stop_det_o = stop_det && en_i;

endmodule

// File: rtl/i2c_sc_decide.sv
module i2c_sc_decide (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic trig_wr_i,
    input  logic stop_req_i,
    input  logic release_i,
    input  logic arb_lost_i,
    input  logic rsv_dis_i,
    input  logic rej_clr_i,
    input  logic mst_wait_i,
    input  logic mst_rx_i,
    input  logic ack_en_i,
    input  logic busy_i,
    input  logic free_i,
    input  logic stop_det_i,
    input  logic seq_idle_i,
    input  logic seq_finish_i,
    output logic trig_o,
    output logic rej_o,
    output logic owner_o,
    output logic go_start_o,
    output logic go_restart_o
);
    typedef struct packed {
        logic trig;
        logic rej;
        logic owner;
    } dec_t;

    dec_t q, d;
    logic kill;
    logic wr_ok;
    logic restart_ok;
    logic reject;
    logic take_new;

    always_comb begin
        kill       = !en_i || arb_lost_i || release_i;
        wr_ok      = trig_wr_i && !stop_req_i && !q.trig && !kill;
        restart_ok = q.owner && mst_wait_i && (!mst_rx_i || !ack_en_i);
        reject     = wr_ok && !q.owner && !free_i && busy_i && rsv_dis_i;
        take_new   = wr_ok && !q.owner && !reject;

        go_restart_o = wr_ok && restart_ok;
        go_start_o   = seq_idle_i && !q.owner && free_i && !kill &&
                       (q.trig || take_new);

        d = q;
        if (kill) begin
            d.trig = 1'b0;
        end else if (seq_finish_i) begin
            d.trig = 1'b0;
        end else if (take_new || go_restart_o) begin
            d.trig = 1'b1;
        end

        if (kill || stop_det_i) begin
            d.owner = 1'b0;
        end else if (seq_finish_i) begin
            d.owner = 1'b1;
        end

        if (!en_i) begin
            d.rej = 1'b0;
        end else if (reject) begin
            d.rej = 1'b1;
        end else if (rej_clr_i) begin
            d.rej = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign trig_o  = q.trig;
    assign rej_o   = q.rej;
    assign owner_o = q.owner;

endmodule

// File: rtl/i2c_sc_seq.sv
module i2c_sc_seq
    import i2c_sc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             arb_lost_i,
    input  logic             release_i,
    input  logic             owner_i,
    input  logic             go_start_i,
    input  logic             go_restart_i,
    input  logic [CNT_W-1:0] hmin_i,
    output logic             sda_oe_o,
    output logic             scl_oe_o,
    output logic             idle_o,
    output logic             finish_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic last;
    logic abort;

    always_comb begin
        last   = (q.cnt >= (hmin_i - CNT_ONE));
        abort  = !en_i || arb_lost_i || release_i;
        d      = q;
        d.done = 1'b0;
        finish_o = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                d.cnt = '0;
                if (go_restart_i) begin
                    d.st = SQ_RS_SDA;
                end else if (go_start_i) begin
                    d.st = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                if (last) begin
                    d.st     = SQ_MWAIT;
                    d.cnt    = '0;
                    d.done   = 1'b1;
                    finish_o = !abort;
                end else begin
                    d.cnt = q.cnt + CNT_ONE;
                end
            end
            SQ_MWAIT: begin
                d.cnt = '0;
                if (go_restart_i) begin
                    d.st = SQ_RS_SDA;
                end else if (!owner_i) begin
                    d.st = SQ_IDLE;
                end
            end
            SQ_RS_SDA: begin
                if (last) begin
                    d.st  = SQ_RS_SCL;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_ONE;
                end
            end
            SQ_RS_SCL: begin
                if (last) begin
                    d.st  = SQ_HOLD;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_ONE;
                end
            end
            default: begin
                d.st  = SQ_IDLE;
                d.cnt = '0;
            end
        endcase
        if (abort) begin
            d.st   = SQ_IDLE;
            d.cnt  = '0;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = (q.st == SQ_HOLD) || (q.st == SQ_MWAIT);
    assign scl_oe_o = (q.st == SQ_MWAIT) || (q.st == SQ_RS_SDA);
    assign idle_o   = (q.st == SQ_IDLE);
    assign done_o   = q.done;

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] hold_cnt_i,
    input  logic             trig_wr_i,
    input  logic             stop_req_i,
    input  logic             release_i,
    input  logic             rej_clr_i,
    input  logic             rsv_dis_i,
    input  logic             arb_lost_i,
    input  logic             mst_wait_i,
    input  logic             mst_rx_i,
    input  logic             ack_en_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             trig_o,
    output logic             rej_o,
    output logic             start_done_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] hmin;
    logic busy;
    logic free;
    logic stop_det;
    logic owner;
    logic go_start;
    logic go_restart;
    logic seq_idle;
    logic seq_finish;

    assign hmin = (hold_cnt_i == '0) ? CNT_ONE : hold_cnt_i;

    i2c_sc_busmon #(.CNT_W(CNT_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .hmin_i     (hmin),
        .busy_o     (busy),
        .free_o     (free),
        .stop_det_o (stop_det)
    );

    i2c_sc_decide u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .trig_wr_i    (trig_wr_i),
        .stop_req_i   (stop_req_i),
        .release_i    (release_i),
        .arb_lost_i   (arb_lost_i),
        .rsv_dis_i    (rsv_dis_i),
        .rej_clr_i    (rej_clr_i),
        .mst_wait_i   (mst_wait_i),
        .mst_rx_i     (mst_rx_i),
        .ack_en_i     (ack_en_i),
        .busy_i       (busy),
        .free_i       (free),
        .stop_det_i   (stop_det),
        .seq_idle_i   (seq_idle),
        .seq_finish_i (seq_finish),
        .trig_o       (trig_o),
        .rej_o        (rej_o),
        .owner_o      (owner),
        .go_start_o   (go_start),
        .go_restart_o (go_restart)
    );

    i2c_sc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .arb_lost_i   (arb_lost_i),
        .release_i    (release_i),
        .owner_i      (owner),
        .go_start_i   (go_start),
        .go_restart_i (go_restart),
        .hmin_i       (hmin),
        .sda_oe_o     (sda_oe_o),
        .scl_oe_o     (scl_oe_o),
        .idle_o       (seq_idle),
        .finish_o     (seq_finish),
        .done_o       (start_done_o)
    );

endmodule

// File: rtl/i2c_start_ctrl_chk.sv
module i2c_start_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic trig_wr_i,
    input logic stop_req_i,
    input logic release_i,
    input logic rej_clr_i,
    input logic arb_lost_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic trig_o,
    input logic rej_o,
    input logic start_done_o
);
    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_done_o |=> !start_done_o);

    a_r1_done_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        start_done_o |-> (scl_oe_o && sda_oe_o && !trig_o));

    a_r5_reject_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rej_o) |-> !trig_o);

    a_r7_clear_events: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i || release_i || !en_i) |=> !trig_o);

    a_r7_abort_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i || release_i) |=> (!scl_oe_o && !sda_oe_o));

    a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr_i && stop_req_i && !trig_o) |=> !trig_o);

    a_r6_rej_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_o && en_i && !rej_clr_i) |=> rej_o);

endmodule

bind i2c_start_ctrl i2c_start_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .trig_wr_i    (trig_wr_i),
    .stop_req_i   (stop_req_i),
    .release_i    (release_i),
    .rej_clr_i    (rej_clr_i),
    .arb_lost_i   (arb_lost_i),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .trig_o       (trig_o),
    .rej_o        (rej_o),
    .start_done_o (start_done_o)
);

// File: tb/i2c_start_ctrl_tb_top.sv
module i2c_start_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [CW-1:0] hold = 8'd4;
    logic trig_wr = 1'b0, stop_req = 1'b0, rel = 1'b0, rej_clr = 1'b0;
    logic rsv_dis = 1'b0, arb = 1'b0, mwait = 1'b0, mrx = 1'b0, acken = 1'b0;
    logic tp_scl = 1'b0, tp_sda = 1'b0;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe, trig, rej, done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign scl_line = !(scl_oe || tp_scl);
    assign sda_line = !(sda_oe || tp_sda);

    i2c_start_ctrl #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .hold_cnt_i(hold),
        .trig_wr_i(trig_wr), .stop_req_i(stop_req), .release_i(rel),
        .rej_clr_i(rej_clr), .rsv_dis_i(rsv_dis), .arb_lost_i(arb),
        .mst_wait_i(mwait), .mst_rx_i(mrx), .ack_en_i(acken),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .trig_o(trig),
        .rej_o(rej), .start_done_o(done)
    );

    function automatic bit restart_expect(bit w, bit rx, bit ack);
        return w && (!rx || !ack);
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic fresh(input int h);
        hold = CW'(h);
        tp_scl = 1'b0; tp_sda = 1'b0;
        en = 1'b0; tick(1);
        en = 1'b1; tick(h + 2);
    endtask

    task automatic write_trig();
        trig_wr = 1'b1; tick(1); trig_wr = 1'b0;
    endtask

    task automatic tp_start();
        tp_sda = 1'b1; tick(2);
        tp_scl = 1'b1; tick(2);
    endtask

    task automatic tp_stop();
        tp_scl = 1'b0; tick(2);
        tp_sda = 1'b0; tick(2);
    endtask

    task automatic free_start(input int h, input string req);
        write_trig();
        chk({req, " sda low"}, sda_oe, 1);
        chk({req, " scl free"}, scl_oe, 0);
        chk({req, " trig set"}, trig, 1);
        tick(h - 1);
        chk({req, " no early done"}, done, 0);
        tick(1);
        chk({req, " done pulse"}, done, 1);
        chk({req, " scl low"}, scl_oe, 1);
        chk({req, " trig cleared"}, trig, 0);
        tick(1);
        chk("R13 done one cycle", done, 0);
    endtask

    task automatic restart_seq(input int h);
        chk("R3 sda released", sda_oe, 0);
        chk("R3 scl held", scl_oe, 1);
        tick(h);
        chk("R3 both released sda", sda_oe, 0);
        chk("R3 both released scl", scl_oe, 0);
        tick(h);
        chk("R3 start sda", sda_oe, 1);
        chk("R3 start scl", scl_oe, 0);
        tick(h);
        chk("R3 done", done, 1);
        chk("R3 trig cleared", trig, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        int h;
        bit w, rx, ak, acc;
        process::self().srandom(32'd1234);
        tick(3);
        chk("reset trig", trig, 0);
        chk("reset rej", rej, 0);
        chk("reset sda_oe", sda_oe, 0);
        chk("reset scl_oe", scl_oe, 0);
        chk("reset done", done, 0);
        rst_n = 1'b1;
        tick(1);

        // R1 free-bus start, R10 and R3 restart in transmit mode
        fresh(4);
        free_start(4, "R1");
        mwait = 1'b0; mrx = 1'b0;
        write_trig();
        chk("R10 refused outside wait", trig, 0);
        chk("R10 lines kept", sda_oe, 1);
        mwait = 1'b1;
        write_trig();
        chk("R10 accepted in wait", trig, 1);
        restart_seq(4);
        // R11 receive mode
        mrx = 1'b1; acken = 1'b1;
        tick(1);
        write_trig();
        chk("R11 refused with ack on", trig, 0);
        acken = 1'b0;
        write_trig();
        chk("R11 accepted ack off", trig, 1);
        restart_seq(4);
        mwait = 1'b0; mrx = 1'b0;

        // R2 hold count of zero behaves as one
        fresh(0);
        write_trig();
        chk("R2 sda low", sda_oe, 1);
        chk("R2 not yet done", done, 0);
        tick(1);
        chk("R2 done after one", done, 1);

        // R8 request with stop request
        fresh(3);
        stop_req = 1'b1; write_trig(); stop_req = 1'b0;
        chk("R8 trig stays 0", trig, 0);
        chk("R8 no sda", sda_oe, 0);
        tick(3);
        chk("R8 still no sda", sda_oe, 0);

        // R12 bus not yet free after enable -> pending, launches at H
        hold = 8'd6;
        en = 1'b0; tick(1); en = 1'b1; tick(2);
        write_trig();
        chk("R12 pending trig", trig, 1);
        chk("R12 not free yet", sda_oe, 0);
        tick(3);
        chk("R12 still quiet", sda_oe, 0);
        tick(1);
        chk("R12 launched", sda_oe, 1);

        // R4 reservation, R9 repeated write, launch after stop
        fresh(4);
        tp_start();
        write_trig();
        chk("R4 pending trig", trig, 1);
        chk("R4 no sda", sda_oe, 0);
        tick(3);
        chk("R4 still no scl", scl_oe, 0);
        rsv_dis = 1'b1;
        write_trig();
        chk("R9 no reject", rej, 0);
        chk("R9 trig kept", trig, 1);
        rsv_dis = 1'b0;
        tp_scl = 1'b0; tick(2);
        tp_sda = 1'b0;
        tick(5);
        chk("R4 waits bus free", sda_oe, 0);
        tick(1);
        chk("R4 launched", sda_oe, 1);
        tick(4);
        chk("R4 done", done, 1);

        // R5 / R6 rejection
        fresh(4);
        tp_start();
        rsv_dis = 1'b1;
        write_trig();
        chk("R5 trig 0", trig, 0);
        chk("R5 rej 1", rej, 1);
        tick(5);
        chk("R6 rej held", rej, 1);
        chk("R5 no sda", sda_oe, 0);
        rej_clr = 1'b1; write_trig(); rej_clr = 1'b0;
        chk("R6 set wins over clear", rej, 1);
        rej_clr = 1'b1; tick(1); rej_clr = 1'b0;
        chk("R6 cleared", rej, 0);
        write_trig();
        chk("R6 set again", rej, 1);
        en = 1'b0; tick(1); en = 1'b1;
        chk("R6 enable drop clears", rej, 0);
        rsv_dis = 1'b0;
        tp_stop();

        // R7 arbitration loss aborts
        fresh(4);
        write_trig(); tick(1);
        arb = 1'b1; tick(1); arb = 1'b0;
        chk("R7 arb trig", trig, 0);
        chk("R7 arb sda", sda_oe, 0);
        chk("R7 arb scl", scl_oe, 0);
        // R7 release on pending
        fresh(4);
        tp_start();
        write_trig();
        rel = 1'b1; tick(1); rel = 1'b0;
        chk("R7 release trig", trig, 0);
        tp_stop(); tick(10);
        chk("R7 no start after release", sda_oe, 0);
        // R7 enable drop on pending
        fresh(4);
        tp_start();
        write_trig();
        en = 1'b0; tick(1); en = 1'b1;
        chk("R7 enable trig", trig, 0);
        tp_stop();

        // random restart attempts
        for (int it = 0; it < 16; it++) begin
            h = 1 + int'($urandom_range(4));
            w = 1'($urandom_range(1));
            rx = 1'($urandom_range(1));
            ak = 1'($urandom_range(1));
            acc = restart_expect(w, rx, ak);
            fresh(h);
            free_start(h, "R1 rand");
            mwait = w; mrx = rx; acken = ak;
            write_trig();
            chk(rx ? "R11 rand accept" : "R10 rand accept", trig, int'(acc));
            if (acc) restart_seq(h);
            else chk("R10 rand lines kept", scl_oe, 1);
            mwait = 1'b0; mrx = 1'b0; acken = 1'b0;
        end

        report();
    end

endmodule